// File: doc/BRIEF.md
# Random-Word Generator Register Interface

This block is the register front end of a random number source that sits on a simple 32-bit word bus. Software talks to it through four word registers: control, status, entropy and output. A seeded shift-register generator runs inside the block. Software may fold extra entropy words into the generator state at any time. Once generation is switched on, the block fills a single-word output holding register. Reading that register hands the word to software and empties it, so the next word has to be generated again.

The block records an underflow whenever software reads the output while it is empty. Three status flags record that event, and each one clears in a different way. One flag clears when status is read. One clears when status is read or when a valid word is read. The third clears only when software writes a clear command. That third flag drives an interrupt output, which software can mask. Two controls can be set but can never be cleared by software: the generation enable and the security-reporting enable. A security-violation flag is also permanent until reset. Generation pauses while the block is asleep. Sleep is requested either by a control bit or by an external doze input.

Top module: `rwg_regif`

## Requirements
- R1: After reset, control reads 0x00000000 and status reads 0x00010000, and the interrupt is low. The status value holds the level field in bits 15:8 (0 = empty, 1 = full) and a constant capacity of 1 in bits 23:16. Register offsets are control 0x0, status 0x4, entropy 0x8 and output 0xC.
- R2: Writing 1 to control bit 0 enables generation, and writing 0 later does not clear it. With generation enabled, the block awake and the level at 0, the level becomes 1 exactly LOAD_STEPS clock edges after the edge that set the enable.
- R3: A read of the output while the level is 1 returns the held word. That word is never zero and differs from the previously delivered word. After the read, the level and the output register are both 0.
- R4: A read of the output while the level is 0 returns 0 and sets status bit 1 (last read underflowed), bit 2 (underflow seen) and bit 3 (error).
- R5: A status read returns the flags as they stood before the read, then clears bits 1 and 2. Bit 3 is left unchanged.
- R6: A valid output read clears status bit 1 and leaves bits 2 and 3 unchanged.
- R7: Writing 1 to control bit 3 clears status bit 3. Control bit 3 always reads 0.
- R8: The interrupt output is high exactly when status bit 3 is 1 and control bit 2 (mask) is 0.
- R9: Control bit 1 (security reporting) cannot be cleared once set. While it is set, an empty output read sets status bit 0, and only reset clears status bit 0.
- R10: Status bit 4 is 1 when control bit 4 is 1 or the doze input is high. While asleep, no word is loaded and the level stays 0.
- R11: The entropy register reads 0. Control bits above bit 4 read 0 and ignore writes. Writes to status or output have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| doze_i | input | 1 | External request to sleep |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; read side effects apply at the closing edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq_o | output | 1 | Error interrupt |

## Verification
Assertions placed beside the logic check the following on every cycle:
- the enable and security flags stay set once set;
- an empty output read raises all three underflow flags, and a status read drops two of them;
- an unmasked underflow drives the interrupt;
- a valid read leaves the holding register empty;
- a held word is never zero;
- a sleeping block never loads.

Only the bench scenarios can show the following:
- the exact load latency after enabling;
- that each delivered word is fresh;
- the different clearing rules seen side by side;
- the effect of writes to reserved bits and read-only registers;
- that reset is the only way to drop the sticky state.

// File: rtl/rwg_pkg.sv
package rwg_pkg;

  localparam int unsigned WORD_W = 32;

  // word index taken from address bits 3:2
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_STAT = 2'd1;
  localparam logic [1:0] IDX_ENT  = 2'd2;
  localparam logic [1:0] IDX_OUT  = 2'd3;

  // control bit positions
  localparam int unsigned CB_GO   = 0;
  localparam int unsigned CB_SEC  = 1;
  localparam int unsigned CB_MASK = 2;
  localparam int unsigned CB_CLR  = 3;
  localparam int unsigned CB_SLP  = 4;

  // status bit positions
  localparam int unsigned SB_SECV  = 0;
  localparam int unsigned SB_LAST  = 1;
  localparam int unsigned SB_UNDER = 2;
  localparam int unsigned SB_ERR   = 3;
  localparam int unsigned SB_SLP   = 4;
  localparam int unsigned SB_LVL   = 8;
  localparam int unsigned SB_SIZE  = 16;

  typedef struct packed {
    logic go;
    logic sec;
    logic mask;
    logic slp;
  } ctrl_t;

  typedef struct packed {
    logic secv;
    logic last;
    logic under;
    logic err;
  } flags_t;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_ent;
    logic rd_ctrl;
    logic rd_stat;
    logic rd_ent;
    logic rd_out;
  } strobe_t;

endpackage

// File: rtl/rwg_decode.sv
module rwg_decode
  import rwg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output strobe_t           stb
);

  logic       hi_zero;
  logic       hit;
  logic [1:0] idx;

  generate
    if (ADDR_W > 4) begin : g_wide
      assign hi_zero = (addr[ADDR_W-1:4] == '0);
    end else begin : g_narrow
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign idx = addr[3:2];
  assign hit = hi_zero && (addr[1:0] == 2'b00);

  always_comb begin
    stb = '0;
    if (hit) begin
      unique case (idx)
        IDX_CTRL: begin
          stb.wr_ctrl = wr;
          stb.rd_ctrl = rd;
        end
        IDX_STAT: stb.rd_stat = rd;
        IDX_ENT: begin
          stb.wr_ent = wr;
          stb.rd_ent = rd;
        end
        default: stb.rd_out = rd;
      endcase
    end
  end

endmodule

// File: rtl/rwg_ctrl.sv
module rwg_ctrl
  import rwg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       rd_stat,
  input  logic [4:0] wbits,
  input  logic       underflow,
  input  logic       valid_rd,
  output ctrl_t      ctrl_q,
  output flags_t     flags_q
);

  ctrl_t  ctrl_d;
  flags_t flags_d;
  logic   clr_err;
  logic   flags_en;

  assign clr_err  = wr_ctrl && wbits[CB_CLR];
  assign flags_en = underflow || rd_stat || valid_rd || clr_err;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.go   = ctrl_q.go  | wbits[CB_GO];
      ctrl_d.sec  = ctrl_q.sec | wbits[CB_SEC];
      ctrl_d.mask = wbits[CB_MASK];
      ctrl_d.slp  = wbits[CB_SLP];
    end
  end

  always_comb begin
    flags_d = flags_q;
    if (underflow) begin
      flags_d.last  = 1'b1;
      flags_d.under = 1'b1;
      flags_d.err   = 1'b1;
      if (ctrl_q.sec) flags_d.secv = 1'b1;
    end else begin
      if (rd_stat || valid_rd) flags_d.last = 1'b0;
      if (rd_stat)             flags_d.under = 1'b0;
      if (clr_err)             flags_d.err = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      flags_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= ctrl_d;
      if (flags_en) flags_q <= flags_d;
    end
  end

  p_go_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.go |=> ctrl_q.go);

  p_sec_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.sec |=> ctrl_q.sec);

  p_secv_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.secv |=> flags_q.secv);

  p_underflow_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (flags_q.last && flags_q.under && flags_q.err));

  p_status_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !underflow) |=> (!flags_q.last && !flags_q.under));

  p_err_holds_on_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !clr_err && flags_q.err) |=> flags_q.err);

endmodule

// File: rtl/rwg_gen.sv
module rwg_gen #(
  parameter int unsigned W             = 32,
  parameter int unsigned LOAD_STEPS    = 8,
  parameter int unsigned STEPS_PER_CLK = 1,
  parameter logic [W-1:0] TAPS         = 32'h8020_0003,
  parameter logic [W-1:0] SEED         = 32'h1234_5679
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         asleep,
  input  logic         ent_wr,
  input  logic [W-1:0] ent_data,
  input  logic         out_rd,
  output logic [W-1:0] word_q,
  output logic         level_q
);

  localparam int unsigned CNT_W = (LOAD_STEPS > 1) ? $clog2(LOAD_STEPS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOAD_STEPS - 1);

  logic [W-1:0]     lfsr_q, lfsr_d, lfsr_adv, lfsr_base, lfsr_mix;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     word_d;
  logic             level_d;
  logic             lfsr_en, cnt_en, out_en;
  logic             load;

  function automatic logic [W-1:0] lfsr_step(input logic [W-1:0] s);
    return {1'b0, s[W-1:1]} ^ (s[0] ? TAPS : '0);
  endfunction

  always_comb begin
    lfsr_adv = lfsr_q;
    for (int k = 0; k < int'(STEPS_PER_CLK); k++) begin
      lfsr_adv = lfsr_step(lfsr_adv);
    end
  end

  // generator: steps only while awake, entropy folded in on every write
  always_comb begin
    lfsr_base = asleep ? lfsr_q : lfsr_adv;
    lfsr_mix  = lfsr_base ^ ent_data;
    lfsr_d    = lfsr_base;
    if (ent_wr) lfsr_d = (lfsr_mix == '0) ? SEED : lfsr_mix;
  end
  assign lfsr_en = !asleep || ent_wr;

  // load timer
  assign load = go && !asleep && !level_q && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (level_q || !go) cnt_d = '0;
    else if (!asleep)   cnt_d = load ? '0 : cnt_q + 1'b1;
  end
  assign cnt_en = (cnt_d != cnt_q);

  // single-word holding register
  always_comb begin
    word_d  = word_q;
    level_d = level_q;
    if (out_rd && level_q) begin
      word_d  = '0;
      level_d = 1'b0;
    end else if (load) begin
      word_d  = lfsr_q;
      level_d = 1'b1;
    end
  end
  assign out_en = (out_rd && level_q) || load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= SEED;
      cnt_q   <= '0;
      word_q  <= '0;
      level_q <= 1'b0;
    end else begin
      if (lfsr_en) lfsr_q <= lfsr_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (out_en) begin
        word_q  <= word_d;
        level_q <= level_d;
      end
    end
  end

  p_read_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rd && level_q) |=> (!level_q && word_q == '0));

  p_word_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level_q |-> (word_q != '0));

  p_no_load_asleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !level_q) |=> !level_q);

  p_no_load_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !level_q) |=> !level_q);

endmodule

// File: rtl/rwg_regif.sv
module rwg_regif
  import rwg_pkg::*;
#(
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned LOAD_STEPS    = 8,
  parameter int unsigned STEPS_PER_CLK = 1,
  parameter logic [31:0] TAPS          = 32'h8020_0003,
  parameter logic [31:0] SEED          = 32'h1234_5679
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              doze_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  strobe_t           stb;
  ctrl_t             ctrl_q;
  flags_t            flags_q;
  logic [WORD_W-1:0] word_q;
  logic              level_q;
  logic              asleep;
  logic              underflow;
  logic              valid_rd;

  // reset: asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rwg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .stb  (stb)
  );

  assign asleep    = ctrl_q.slp || doze_i;
  assign underflow = stb.rd_out && !level_q;
  assign valid_rd  = stb.rd_out && level_q;

  rwg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_ctrl   (stb.wr_ctrl),
    .rd_stat   (stb.rd_stat),
    .wbits     (bus_wdata[4:0]),
    .underflow (underflow),
    .valid_rd  (valid_rd),
    .ctrl_q    (ctrl_q),
    .flags_q   (flags_q)
  );

  rwg_gen #(
    .W             (WORD_W),
    .LOAD_STEPS    (LOAD_STEPS),
    .STEPS_PER_CLK (STEPS_PER_CLK),
    .TAPS          (TAPS),
    .SEED          (SEED)
  ) u_gen (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .go       (ctrl_q.go),
    .asleep   (asleep),
    .ent_wr   (stb.wr_ent),
    .ent_data (bus_wdata),
    .out_rd   (stb.rd_out),
    .word_q   (word_q),
    .level_q  (level_q)
  );

  assign irq_o = flags_q.err && !ctrl_q.mask;

  always_comb begin
    bus_rdata = '0;
    if (stb.rd_ctrl) begin
      bus_rdata[CB_GO]   = ctrl_q.go;
      bus_rdata[CB_SEC]  = ctrl_q.sec;
      bus_rdata[CB_MASK] = ctrl_q.mask;
      bus_rdata[CB_SLP]  = ctrl_q.slp;
    end else if (stb.rd_stat) begin
      bus_rdata[SB_SECV]          = flags_q.secv;
      bus_rdata[SB_LAST]          = flags_q.last;
      bus_rdata[SB_UNDER]         = flags_q.under;
      bus_rdata[SB_ERR]           = flags_q.err;
      bus_rdata[SB_SLP]           = asleep;
      bus_rdata[SB_LVL +: 8]      = {7'd0, level_q};
      bus_rdata[SB_SIZE +: 8]     = 8'd1;
    end else if (stb.rd_out) begin
      bus_rdata = word_q;
    end
  end

  p_irq_on_error_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (underflow && !ctrl_q.mask) |=> irq_o);

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctrl_q.mask |-> !irq_o);

  p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    underflow |-> (bus_rdata == '0));

endmodule

// File: tb/rwg_regif_test.sv
module rwg_regif_test;

  localparam int LOAD = 8;
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_STAT = 4'h4;
  localparam logic [3:0] A_ENT  = 4'h8;
  localparam logic [3:0] A_OUT  = 4'hC;
  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  logic        clk;
  logic        rst_n;
  logic        doze;
  logic [3:0]  addr;
  logic        wr;
  logic        rd;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  logic [31:0] mask_q[$];
  int          kind_q[$];
  string       tag_q[$];
  logic [31:0] prev_word = '0;

  rwg_regif #(.LOAD_STEPS(LOAD)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .doze_i    (doze),
    .bus_addr  (addr),
    .bus_wr    (wr),
    .bus_rd    (rd),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per read cycle
  always @(negedge clk) begin
    if (rd && rst_n) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "scoreboard empty", rdata, '0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic logic [31:0] m = mask_q.pop_front();
        automatic int          k = kind_q.pop_front();
        automatic string       t = tag_q.pop_front();
        if (k == 0) begin
          chk((rdata & m) == (e & m), t, rdata & m, e & m);
        end else begin
          chk(rdata != '0 && rdata != prev_word, t, rdata, prev_word);
          prev_word = rdata;
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      wr = 1'b0; rd = 1'b0;
    end
  endtask

  task automatic op_write(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
  endtask

  task automatic op_read(input logic [3:0] a, input logic [31:0] e,
                         input logic [31:0] m, input int k, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(e); mask_q.push_back(m); kind_q.push_back(k); tag_q.push_back(tag);
    addr = a; wr = 1'b0; rd = 1'b1;
  endtask

  task automatic set_doze(input logic v);
    @(posedge clk); #1;
    doze = v; wr = 1'b0; rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    idle(1);
    @(negedge clk);
    chk(irq == e, tag, {31'd0, irq}, {31'd0, e});
  endtask

  task automatic do_reset;
    @(posedge clk); #1;
    wr = 1'b0; rd = 1'b0; rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  initial begin
    rst_n = 1'b0; doze = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    op_read(A_CTRL, 32'h0, ALL, 0, "R1 control reset");
    op_read(A_STAT, 32'h0001_0000, ALL, 0, "R1 status reset");
    chk_irq(1'b0, "R1 irq reset");

    // R4 underflow before enabling, R5 clear on status read
    op_read(A_OUT, 32'h0, ALL, 0, "R4 empty read data");
    op_read(A_STAT, 32'h0001_000E, ALL, 0, "R4 underflow flags");
    chk_irq(1'b1, "R8 irq on error");
    op_read(A_STAT, 32'h0001_0008, ALL, 0, "R5 status read clears last/under");

    // R8 mask, R7 clear command
    op_write(A_CTRL, 32'h4);
    chk_irq(1'b0, "R8 irq masked");
    op_read(A_CTRL, 32'h4, ALL, 0, "R8 mask readback");
    op_write(A_CTRL, 32'hC);
    op_read(A_CTRL, 32'h4, ALL, 0, "R7 clear bit reads 0");
    op_read(A_STAT, 32'h0001_0000, ALL, 0, "R7 error cleared");
    op_write(A_CTRL, 32'h0);

    // R2 load latency
    op_write(A_CTRL, 32'h1);
    idle(LOAD - 1);
    op_read(A_STAT, 32'h0001_0000, ALL, 0, "R2 level 0 one edge early");
    op_read(A_STAT, 32'h0001_0100, ALL, 0, "R2 level 1 on time");
    op_read(A_OUT, 32'h0, 32'h0, 1, "R3 first word fresh");
    op_read(A_OUT, 32'h0, ALL, 0, "R3 output emptied by read");
    op_read(A_STAT, 32'h0001_000E, ALL, 0, "R3 level back to 0");
    op_write(A_CTRL, 32'h0);
    op_read(A_CTRL, 32'h1, ALL, 0, "R2 enable sticky");

    // R6 valid read clears last-read flag only
    op_read(A_OUT, 32'h0, ALL, 0, "R4 second underflow");
    idle(LOAD + 2);
    op_read(A_OUT, 32'h0, 32'h0, 1, "R3 second word fresh");
    op_read(A_STAT, 32'h0001_000C, ALL, 0, "R6 valid read clears last");
    chk_irq(1'b1, "R8 irq unmasked");
    op_write(A_CTRL, 32'h9);
    op_read(A_STAT, 32'h0001_0000, ALL, 0, "R7 clear via command");

    // R9 security reporting, R10 doze
    op_write(A_CTRL, 32'h3);
    set_doze(1'b1);
    op_read(A_OUT, 32'h0, 32'h0, 0, "R9 drain");
    op_read(A_OUT, 32'h0, ALL, 0, "R9 empty read data");
    op_read(A_STAT, 32'h0001_001F, ALL, 0, "R9 violation flag set");
    idle(3 * LOAD);
    op_read(A_STAT, 32'h0001_0019, ALL, 0, "R10 no load while dozing");
    op_write(A_CTRL, 32'h8);
    op_read(A_STAT, 32'h0001_0011, ALL, 0, "R9 violation survives clear");
    op_write(A_CTRL, 32'h0);
    op_read(A_CTRL, 32'h3, ALL, 0, "R9 security enable sticky");
    set_doze(1'b0);
    idle(LOAD + 2);
    op_read(A_STAT, 32'h0001_0101, ALL, 0, "R10 loads after wake");
    op_read(A_OUT, 32'h0, 32'h0, 1, "R3 third word fresh");

    // R10 sleep via control bit
    op_write(A_CTRL, 32'h10);
    op_read(A_STAT, 32'h10, 32'h10, 0, "R10 sleep bit from control");
    idle(2 * LOAD);
    op_read(A_STAT, 32'h0, 32'hFF00, 0, "R10 level held at 0 asleep");
    op_read(A_CTRL, 32'h13, ALL, 0, "R10 control readback");

    // R11 reserved bits, entropy, read-only registers
    op_write(A_CTRL, 32'hFFFF_FFE0);
    op_read(A_CTRL, 32'h3, ALL, 0, "R11 reserved control bits");
    op_write(A_ENT, 32'hDEAD_BEEF);
    op_read(A_ENT, 32'h0, ALL, 0, "R11 entropy reads 0");
    idle(LOAD + 2);
    op_write(A_STAT, ALL);
    op_write(A_OUT, ALL);
    op_read(A_STAT, 32'h0001_0101, ALL, 0, "R11 status write ignored");
    op_read(A_OUT, 32'h0, 32'h0, 1, "R3 word after entropy fresh");

    // R1 reset clears sticky state
    do_reset();
    op_read(A_CTRL, 32'h0, ALL, 0, "R1 control after reset");
    op_read(A_STAT, 32'h0001_0000, ALL, 0, "R1 status after reset");
    chk_irq(1'b0, "R1 irq after reset");

    idle(2);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule